// File: doc/BRIEF.md
# Mode-Banked Register File with Status Registers

This block is the architectural register store of a 32-bit load-store processor. It has sixteen architectural indices, 0 to 15. Which physical word an index reaches depends on the current operating mode. There are 37 physical 32-bit words in all: 31 general words, one current status word, and five saved status words, one for each exception mode. Two combinational read ports and one synchronous write port reach the general words. The current status word holds the mode field that steers the banking.

The current status word has a 4-bit condition-flag field in its top bits and an 8-bit control field in its low bits, with the mode in bits 4 to 0. In a privileged mode a status write replaces the whole word. In user mode a status write may change only the flags. While an exception mode is active, a separate port reads and writes that mode's saved status word. Index 15 is kept as an ordinary storage slot. Decode, the ALU, exception handling and program-counter arithmetic belong to the surrounding core.

Top module: `banked_regfile`

## Requirements
- R1: After reset every general word reads 0, the status word reads 32'h0000_0013 (supervisor, flags clear) and every saved status word reads 0.
- R2: Both read ports are combinational. A general write becomes visible from the cycle after its clock edge. A read of the word being written in the same cycle returns the old value, and two ports reading the same index return the same value.
- R3: In user mode (mode field 5'b10000) and in system mode (5'b11111), all sixteen indices reach the same shared user words, so the two modes see identical contents.
- R4: In FIQ mode (5'b10001), indices 8 to 14 reach seven private words. Indices 0 to 7 and 15 reach the shared user words.
- R5: IRQ (5'b10010), supervisor (5'b10011), abort (5'b10111) and undefined (5'b11011) each have their own private words for index 13 and index 14. Every other index reaches the shared user words.
- R6: Any mode-field value not listed in R3 to R5 behaves as user mode for banking, for status-write masking and for saved-status access.
- R7: A status write in any privileged mode (all listed modes except user) replaces all 32 bits at the next edge. Without a status write, the status word holds its value.
- R8: A status write in user mode changes only bits 31:28 (N, Z, C, V). Bits 27:0, including the control field 7:0, keep their value.
- R9: In each of the five exception modes, the saved-status port reads and writes that mode's own word, and it is independent of the other four.
- R10: In user or system mode, the saved-status port reads 0 and a saved-status write changes no saved word.
- R11: When a status write that changes the mode shares a cycle with a general write or a saved-status write, those writes go to the bank of the mode in force before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 4 | Architectural index, read port A |
| rd_a_data | output | 32 | Data of read port A |
| rd_b_idx | input | 4 | Architectural index, read port B |
| rd_b_data | output | 32 | Data of read port B |
| wr_en | input | 1 | General write enable |
| wr_idx | input | 4 | Architectural index to write |
| wr_data | input | 32 | General write data |
| st_wr_en | input | 1 | Current status write enable |
| st_wr_data | input | 32 | Current status write data |
| st_rd_data | output | 32 | Current status word |
| sv_wr_en | input | 1 | Saved status write enable for the current mode |
| sv_wr_data | input | 32 | Saved status write data |
| sv_rd_data | output | 32 | Saved status word of the current mode, 0 in user/system |

## Verification
A mode switch through the status port can share a clock edge with a general write or a saved-status write. In that case the written word must land in the bank of the outgoing mode. The bench provokes this by switching supervisor to FIQ while it writes index 13 and the saved word. It then reads index 13 in FIQ mode, switches back, and reads again. A behavioural model that resolves banking from the pre-edge mode judges every port on every cycle, including the random phase, where status writes land at random alongside register writes.

// File: rtl/rb_pkg.sv
package rb_pkg;

   localparam int ARCH_REGS  = 16;
   localparam int IDX_W      = $clog2(ARCH_REGS);
   localparam int MODE_W     = 5;
   localparam int FLAG_W     = 4;
   localparam int CTRL_W     = 8;
   localparam int FIQ_LO     = 8;
   localparam int FIQ_HI     = 14;
   localparam int SP_IDX     = 13;
   localparam int LR_IDX     = 14;
   localparam int SMALL_BANKS = 4;
   localparam int EXC_MODES  = 5;
   localparam int FIQ_BASE   = ARCH_REGS;
   localparam int SMALL_BASE = FIQ_BASE + (FIQ_HI - FIQ_LO + 1);
   localparam int NUM_PHYS   = SMALL_BASE + 2 * SMALL_BANKS;
   localparam int PHYS_W     = $clog2(NUM_PHYS);
   localparam int SLOT_W     = $clog2(EXC_MODES);

   localparam logic [MODE_W-1:0] ENC_USR = 5'b10000;
   localparam logic [MODE_W-1:0] ENC_FIQ = 5'b10001;
   localparam logic [MODE_W-1:0] ENC_IRQ = 5'b10010;
   localparam logic [MODE_W-1:0] ENC_SVC = 5'b10011;
   localparam logic [MODE_W-1:0] ENC_ABT = 5'b10111;
   localparam logic [MODE_W-1:0] ENC_UND = 5'b11011;
   localparam logic [MODE_W-1:0] ENC_SYS = 5'b11111;

   typedef enum logic [2:0] {
      MD_USR, MD_FIQ, MD_IRQ, MD_SVC, MD_ABT, MD_UND, MD_SYS
   } mode_e;

   function automatic mode_e decode_mode(logic [MODE_W-1:0] enc);
      mode_e m;
      case (enc)
         ENC_FIQ: m = MD_FIQ;
         ENC_IRQ: m = MD_IRQ;
         ENC_SVC: m = MD_SVC;
         ENC_ABT: m = MD_ABT;
         ENC_UND: m = MD_UND;
         ENC_SYS: m = MD_SYS;
         default: m = MD_USR;
      endcase
      return m;
   endfunction

   function automatic logic is_priv(mode_e m);
      return m != MD_USR;
   endfunction

   function automatic logic has_saved(mode_e m);
      return (m != MD_USR) && (m != MD_SYS);
   endfunction

   function automatic logic [SLOT_W-1:0] saved_slot(mode_e m);
      logic [SLOT_W-1:0] s;
      case (m)
         MD_FIQ:  s = SLOT_W'(0);
         MD_IRQ:  s = SLOT_W'(1);
         MD_SVC:  s = SLOT_W'(2);
         MD_ABT:  s = SLOT_W'(3);
         MD_UND:  s = SLOT_W'(4);
         default: s = SLOT_W'(0);
      endcase
      return s;
   endfunction

   function automatic logic small_bank(mode_e m);
      return (m == MD_IRQ) || (m == MD_SVC) || (m == MD_ABT) || (m == MD_UND);
   endfunction

   function automatic int unsigned small_slot(mode_e m);
      int unsigned s;
      case (m)
         MD_SVC:  s = 1;
         MD_ABT:  s = 2;
         MD_UND:  s = 3;
         default: s = 0;
      endcase
      return s;
   endfunction

   function automatic logic [PHYS_W-1:0] phys_index(logic [IDX_W-1:0] idx, mode_e m);
      logic [PHYS_W-1:0] r;
      r = PHYS_W'(idx);
      if (m == MD_FIQ && idx >= IDX_W'(FIQ_LO) && idx <= IDX_W'(FIQ_HI))
         r = PHYS_W'(FIQ_BASE) + PHYS_W'(idx - IDX_W'(FIQ_LO));
      else if (small_bank(m) && (idx == IDX_W'(SP_IDX) || idx == IDX_W'(LR_IDX)))
         r = PHYS_W'(SMALL_BASE) + PHYS_W'(2 * small_slot(m))
             + PHYS_W'(idx == IDX_W'(LR_IDX));
      return r;
   endfunction

endpackage

// File: rtl/rb_mode_map.sv
module rb_mode_map
   import rb_pkg::*;
#(
   parameter int NUM_RD = 2
) (
   input  logic [MODE_W-1:0] mode_bits,
   input  logic [IDX_W-1:0]  rd_idx  [NUM_RD],
   input  logic [IDX_W-1:0]  wr_idx,
   output mode_e             mode,
   output logic [PHYS_W-1:0] rd_phys [NUM_RD],
   output logic [PHYS_W-1:0] wr_phys,
   output logic              priv,
   output logic              saved_ok,
   output logic [SLOT_W-1:0] slot
);

   assign mode     = decode_mode(mode_bits);
   assign priv     = is_priv(mode);
   assign saved_ok = has_saved(mode);
   assign slot     = saved_slot(mode);
   assign wr_phys  = phys_index(wr_idx, mode);

   for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
      assign rd_phys[p] = phys_index(rd_idx[p], mode);
   end

endmodule

// File: rtl/rb_gpr_array.sv
module rb_gpr_array #(
   parameter int DATA_W         = 32,
   parameter int NUM_WORDS      = 31,
   parameter int ADDR_W         = 5,
   parameter int NUM_RD         = 2,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr [NUM_RD],
   output logic [DATA_W-1:0] rd_data [NUM_RD]
);

   logic [DATA_W-1:0] words [NUM_WORDS];

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      logic hit;
      assign hit = wr_en && (wr_addr == ADDR_W'(w));
      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   words[w] <= '0;
            else if (hit) words[w] <= wr_data;
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (hit) words[w] <= wr_data;
         end
      end
   end

   for (genvar p = 0; p < NUM_RD; p++) begin : g_port
      assign rd_data[p] = words[rd_addr[p]];
   end

endmodule

// File: rtl/rb_status.sv
module rb_status
   import rb_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              priv,
   input  logic              saved_ok,
   input  logic [SLOT_W-1:0] slot,
   input  logic              st_wr_en,
   input  logic [DATA_W-1:0] st_wr_data,
   input  logic              sv_wr_en,
   input  logic [DATA_W-1:0] sv_wr_data,
   output logic [DATA_W-1:0] st_q,
   output logic [DATA_W-1:0] sv_rd
);

   localparam logic [DATA_W-1:0] FLAG_MASK =
      {{FLAG_W{1'b1}}, {(DATA_W-FLAG_W){1'b0}}};
   localparam logic [DATA_W-1:0] STATUS_RST =
      {{(DATA_W-MODE_W){1'b0}}, ENC_SVC};

   logic [DATA_W-1:0] wmask;
   logic [DATA_W-1:0] sv_q [EXC_MODES];

   assign wmask = priv ? '1 : FLAG_MASK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        st_q <= STATUS_RST;
      else if (st_wr_en) st_q <= (st_q & ~wmask) | (st_wr_data & wmask);
   end

   for (genvar k = 0; k < EXC_MODES; k++) begin : g_saved
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sv_q[k] <= '0;
         else if (sv_wr_en && saved_ok && slot == SLOT_W'(k))
            sv_q[k] <= sv_wr_data;
      end
   end

   assign sv_rd = saved_ok ? sv_q[slot] : '0;

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
   import rb_pkg::*;
#(
   parameter int DATA_W             = 32,
   parameter bit CLEAR_GPR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        rd_a_idx,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [3:0]        rd_b_idx,
   output logic [DATA_W-1:0] rd_b_data,
   input  logic              wr_en,
   input  logic [3:0]        wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              st_wr_en,
   input  logic [DATA_W-1:0] st_wr_data,
   output logic [DATA_W-1:0] st_rd_data,
   input  logic              sv_wr_en,
   input  logic [DATA_W-1:0] sv_wr_data,
   output logic [DATA_W-1:0] sv_rd_data
);

   localparam int NUM_RD = 2;

   if (DATA_W < FLAG_W + CTRL_W) begin : g_bad_width
      $error("DATA_W too small for flag and control fields");
   end
   if (IDX_W != 4) begin : g_bad_idx
      $error("architectural index width must be 4");
   end

   logic [DATA_W-1:0] st_q;
   mode_e             mode;
   logic              priv, saved_ok;
   logic [SLOT_W-1:0] slot;
   logic [PHYS_W-1:0] wr_phys;
   logic [IDX_W-1:0]  rd_idx  [NUM_RD];
   logic [PHYS_W-1:0] rd_phys [NUM_RD];
   logic [DATA_W-1:0] rd_dat  [NUM_RD];

   assign rd_idx[0] = rd_a_idx;
   assign rd_idx[1] = rd_b_idx;

   rb_mode_map #(.NUM_RD(NUM_RD)) u_map (
      .mode_bits (st_q[MODE_W-1:0]),
      .rd_idx    (rd_idx),
      .wr_idx    (wr_idx),
      .mode      (mode),
      .rd_phys   (rd_phys),
      .wr_phys   (wr_phys),
      .priv      (priv),
      .saved_ok  (saved_ok),
      .slot      (slot)
   );

   rb_gpr_array #(
      .DATA_W         (DATA_W),
      .NUM_WORDS      (NUM_PHYS),
      .ADDR_W         (PHYS_W),
      .NUM_RD         (NUM_RD),
      .CLEAR_ON_RESET (CLEAR_GPR_ON_RESET)
   ) u_gpr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_phys),
      .wr_data (wr_data),
      .rd_addr (rd_phys),
      .rd_data (rd_dat)
   );

   rb_status #(.DATA_W(DATA_W)) u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .priv       (priv),
      .saved_ok   (saved_ok),
      .slot       (slot),
      .st_wr_en   (st_wr_en),
      .st_wr_data (st_wr_data),
      .sv_wr_en   (sv_wr_en),
      .sv_wr_data (sv_wr_data),
      .st_q       (st_q),
      .sv_rd      (sv_rd_data)
   );

   assign rd_a_data  = rd_dat[0];
   assign rd_b_data  = rd_dat[1];
   assign st_rd_data = st_q;

endmodule

// File: rtl/rb_checker.sv
module rb_checker #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [3:0]        rd_a_idx,
   input logic [DATA_W-1:0] rd_a_data,
   input logic [3:0]        rd_b_idx,
   input logic [DATA_W-1:0] rd_b_data,
   input logic              st_wr_en,
   input logic [DATA_W-1:0] st_wr_data,
   input logic [DATA_W-1:0] st_rd_data,
   input logic              sv_wr_en,
   input logic [DATA_W-1:0] sv_wr_data,
   input logic [DATA_W-1:0] sv_rd_data
);

   logic user_like, exc_like;

   always_comb begin
      user_like = 1'b1;
      exc_like  = 1'b0;
      case (st_rd_data[4:0])
         5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011: begin
            user_like = 1'b0;
            exc_like  = 1'b1;
         end
         5'b11111: user_like = 1'b0;
         default: ;
      endcase
   end

   AST_PRIV_FULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr_en && !user_like) |=> st_rd_data == $past(st_wr_data)); // R7

   AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !st_wr_en |=> $stable(st_rd_data)); // R7

   AST_USER_CTRL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr_en && user_like) |=>
         st_rd_data[DATA_W-5:0] == $past(st_rd_data[DATA_W-5:0])); // R8

   AST_USER_FLAGS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr_en && user_like) |=>
         st_rd_data[DATA_W-1 -: 4] == $past(st_wr_data[DATA_W-1 -: 4])); // R8

   AST_NO_SAVED_OUTSIDE_EXC: assert property (@(posedge clk) disable iff (!rst_n)
      !exc_like |-> sv_rd_data == '0); // R10

   AST_SAVED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (sv_wr_en && exc_like && !st_wr_en) |=> sv_rd_data == $past(sv_wr_data)); // R9

   AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_a_idx == rd_b_idx) |-> rd_a_data == rd_b_data); // R2

endmodule

bind banked_regfile rb_checker #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_a_idx   (rd_a_idx),
   .rd_a_data  (rd_a_data),
   .rd_b_idx   (rd_b_idx),
   .rd_b_data  (rd_b_data),
   .st_wr_en   (st_wr_en),
   .st_wr_data (st_wr_data),
   .st_rd_data (st_rd_data),
   .sv_wr_en   (sv_wr_en),
   .sv_wr_data (sv_wr_data),
   .sv_rd_data (sv_rd_data)
);

// File: tb/tb_banked_regfile.sv
module tb_banked_regfile;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
   logic [31:0] rd_a_data, rd_b_data, st_rd_data, sv_rd_data;
   logic        wr_en = 1'b0, st_wr_en = 1'b0, sv_wr_en = 1'b0;
   logic [31:0] wr_data = '0, st_wr_data = '0, sv_wr_data = '0;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   banked_regfile dut (
      .clk(clk), .rst_n(rst_n),
      .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
      .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .st_wr_en(st_wr_en), .st_wr_data(st_wr_data), .st_rd_data(st_rd_data),
      .sv_wr_en(sv_wr_en), .sv_wr_data(sv_wr_data), .sv_rd_data(sv_rd_data)
   );

   // reference state: shared words, FIQ words, per-mode sp/lr, saved words
   logic [31:0] m_usr [16];
   logic [31:0] m_fiq [7];
   logic [31:0] m_sp  [4];
   logic [31:0] m_lr  [4];
   logic [31:0] m_sv  [5];
   logic [31:0] m_st;

   // 0 user,1 fiq,2 irq,3 svc,4 abt,5 und,6 sys; unlisted -> user (R6)
   function automatic int mclass(logic [4:0] e);
      case (e)
         5'b10001: return 1;
         5'b10010: return 2;
         5'b10011: return 3;
         5'b10111: return 4;
         5'b11011: return 5;
         5'b11111: return 6;
         default:  return 0;
      endcase
   endfunction

   function automatic logic [31:0] m_read(int idx);
      int c;
      c = mclass(m_st[4:0]);
      if (c == 1 && idx >= 8 && idx <= 14) return m_fiq[idx-8];
      if (c >= 2 && c <= 5 && idx == 13) return m_sp[c-2];
      if (c >= 2 && c <= 5 && idx == 14) return m_lr[c-2];
      return m_usr[idx];
   endfunction

   function automatic logic [31:0] m_saved();
      int c;
      c = mclass(m_st[4:0]);
      if (c >= 1 && c <= 5) return m_sv[c-1];
      return 32'h0;
   endfunction

   task automatic m_reset();
      for (int i = 0; i < 16; i++) m_usr[i] = '0;
      for (int i = 0; i < 7; i++)  m_fiq[i] = '0;
      for (int i = 0; i < 4; i++) begin m_sp[i] = '0; m_lr[i] = '0; end
      for (int i = 0; i < 5; i++)  m_sv[i] = '0;
      m_st = 32'h0000_0013;
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) m_reset();
      else begin
         int c;
         int wi;
         c  = mclass(m_st[4:0]);
         wi = int'(wr_idx);
         if (wr_en) begin
            if (c == 1 && wi >= 8 && wi <= 14)           m_fiq[wi-8] = wr_data;
            else if (c >= 2 && c <= 5 && wi == 13)       m_sp[c-2]   = wr_data;
            else if (c >= 2 && c <= 5 && wi == 14)       m_lr[c-2]   = wr_data;
            else                                         m_usr[wi]   = wr_data;
         end
         if (sv_wr_en && c >= 1 && c <= 5) m_sv[c-1] = sv_wr_data;
         if (st_wr_en) begin
            if (c == 0) m_st = {st_wr_data[31:28], m_st[27:0]};
            else        m_st = st_wr_data;
         end
      end
   end

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s got %h exp %h", tag, what, act, exp);
      end
   endtask

   task automatic compare(string tag);
      chk(tag, "rd_a", rd_a_data, m_read(int'(rd_a_idx)));
      chk(tag, "rd_b", rd_b_data, m_read(int'(rd_b_idx)));
      chk(tag, "status", st_rd_data, m_st);
      chk(tag, "saved", sv_rd_data, m_saved());
   endtask

   task automatic cyc(string tag, logic we, int wi, logic [31:0] wd,
                      logic se, logic [31:0] sd, logic ve, logic [31:0] vd,
                      int ra, int rb);
      @(negedge clk);
      wr_en = we; wr_idx = 4'(wi); wr_data = wd;
      st_wr_en = se; st_wr_data = sd;
      sv_wr_en = ve; sv_wr_data = vd;
      rd_a_idx = 4'(ra); rd_b_idx = 4'(rb);
      #1 compare(tag);
   endtask

   task automatic idle(string tag, int ra, int rb);
      cyc(tag, 1'b0, 0, 0, 1'b0, 0, 1'b0, 0, ra, rb);
   endtask

   task automatic set_mode(string tag, logic [31:0] st);
      cyc(tag, 1'b0, 0, 0, 1'b1, st, 1'b0, 0, 0, 15);
   endtask

   task automatic scan(string tag);
      for (int i = 0; i < 16; i += 2) idle(tag, i, i + 1);
   endtask

   task automatic do_reset();
      @(negedge clk);
      wr_en = 0; st_wr_en = 0; sv_wr_en = 0;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [4:0] encs [8];
      encs = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
               5'b10111, 5'b11011, 5'b11111, 5'b10101};
      m_reset();

      // R1: reset state
      do_reset();
      scan("R1");

      // R2: write in supervisor; same-cycle read returns old, next cycle new
      for (int i = 0; i < 16; i++)
         cyc("R2", 1'b1, i, 32'h1000 + i, 1'b0, 0, 1'b0, 0, i, (i + 15) % 16);
      scan("R2");

      // R4: FIQ private 8..14, shared 0..7 and 15
      set_mode("R4", 32'h0000_0011);
      for (int i = 0; i < 16; i++)
         cyc("R4", 1'b1, i, 32'hF000 + i, 1'b0, 0, 1'b0, 0, i, 15 - i);
      scan("R4");
      set_mode("R4", 32'h0000_0013);
      scan("R4");

      // R5: IRQ, abort, undefined private sp/lr
      foreach (encs[k]) begin
         if (k == 2 || k == 4 || k == 5) begin
            set_mode("R5", {27'h0, encs[k]});
            cyc("R5", 1'b1, 13, 32'hA000 + k, 1'b0, 0, 1'b0, 0, 13, 14);
            cyc("R5", 1'b1, 14, 32'hB000 + k, 1'b0, 0, 1'b0, 0, 13, 14);
            cyc("R5", 1'b1, 12, 32'hC000 + k, 1'b0, 0, 1'b0, 0, 12, 13);
            scan("R5");
         end
      end

      // R9: each exception mode keeps its own saved word
      for (int k = 1; k <= 5; k++) begin
         set_mode("R9", {27'h0, encs[k]});
         cyc("R9", 1'b0, 0, 0, 1'b0, 0, 1'b1, 32'h5A00_0000 + k, 13, 14);
         idle("R9", 13, 14);
      end
      for (int k = 1; k <= 5; k++) begin
         set_mode("R9", {27'h0, encs[k]});
         idle("R9", 8, 14);
      end

      // R7: privileged write replaces every field
      set_mode("R7", 32'h5123_4512);
      idle("R7", 13, 14);
      set_mode("R7", 32'hF000_0013);
      idle("R7", 13, 14);

      // R3: system then user see the shared words
      set_mode("R3", 32'h0000_001F);
      scan("R3");
      cyc("R3", 1'b1, 13, 32'h5555_0013, 1'b0, 0, 1'b0, 0, 13, 14);
      set_mode("R3", 32'h0000_0010);
      scan("R3");

      // R10: saved port reads zero, writes ignored in user mode
      cyc("R10", 1'b0, 0, 0, 1'b0, 0, 1'b1, 32'hDEAD_BEEF, 0, 1);
      idle("R10", 0, 1);

      // R8: user status write touches only the flags
      set_mode("R8", 32'hA0FF_FF9F);
      idle("R8", 0, 1);
      set_mode("R8", 32'h5000_0011);
      idle("R8", 8, 13);

      // R6: unlisted mode field behaves as user
      do_reset();
      idle("R1", 13, 14);
      cyc("R6", 1'b1, 13, 32'h0BAD_0013, 1'b0, 0, 1'b0, 0, 13, 14);
      set_mode("R6", 32'h0000_0015);
      idle("R6", 13, 14);
      cyc("R6", 1'b0, 0, 0, 1'b0, 0, 1'b1, 32'h1234_5678, 13, 14);
      set_mode("R6", 32'hC000_0013);
      idle("R6", 13, 14);

      // R11: mode change in the same cycle as banked writes
      do_reset();
      cyc("R11", 1'b1, 13, 32'h7777_0013, 1'b1, 32'h0000_0011, 1'b1, 32'h3333_0013, 13, 14);
      idle("R11", 13, 8);
      cyc("R11", 1'b1, 14, 32'h8888_0011, 1'b1, 32'h0000_0013, 1'b0, 0, 14, 13);
      idle("R11", 13, 14);
      set_mode("R11", 32'h0000_0011);
      idle("R11", 14, 13);

      // random phase, judged by the model (R2 plus all banking rules)
      for (int n = 0; n < 4000; n++) begin
         logic [31:0] sd;
         if (n % 250 == 0) do_reset();
         sd = {$urandom()} & 32'hFFFF_FFE0;
         sd[4:0] = encs[$urandom_range(0, 7)];
         cyc("R2", 1'($urandom_range(0, 1)), $urandom_range(0, 15), $urandom(),
             ($urandom_range(0, 7) == 0), sd,
             ($urandom_range(0, 3) == 0), $urandom(),
             $urandom_range(0, 15), $urandom_range(0, 15));
      end

      finish_run();
   end

endmodule